// File: doc/BRIEF.md
# Oscillator Ratio Divider

This block divides a fast internal oscillator clock by a power of two chosen through a two-bit ratio code. Its output is not a gated clock but a clock-enable pulse. Logic running on the undivided clock uses the pulse to act at the divided rate. A write strobe with a data field programs the ratio.

A programmed ratio does not reach the output at once. The divider first completes the output period it is in. It then loads the new ratio at the counter wrap, so no period is ever cut short. A settled flag tells software whether the output already runs at the programmed ratio.

While a PLL is enabled and uses the divided clock as its reference, the ratio is frozen. A write during that time is discarded.

Top module: `osc_ratio_div`

## Requirements
- R1: Ratio code k (0 to 3) divides by 2^k. Code 0 is 64 MHz, code 1 is 32 MHz, code 2 is 16 MHz and code 3 is 8 MHz. `tick_o` is a one-cycle pulse once every 2^k source cycles, and it stays high continuously for code 0.
- R2: After reset the active and programmed ratio is code 0, `tick_o` is high and `settled_o` is 1.
- R3: A write (`wr_en_i` high, `pll_ref_busy_i` low) stores `wr_ratio_i` at that clock edge. If the stored value differs from the active ratio, `settled_o` reads 0 from the cycle after the write.
- R4: Writing the ratio that is already programmed and active leaves `settled_o` at 1, and the tick spacing does not change.
- R5: The active ratio changes only at the counter wrap, which is the edge that ends a `tick_o` cycle. The old period therefore always completes, so `settled_o` stays low for at most one old period after a write.
- R6: `settled_o` returns to 1 in the first cycle of the new ratio. From that cycle on, the tick spacing matches the programmed code.
- R7: A write while `pll_ref_busy_i` is high is discarded. `settled_o` stays 1 and the tick spacing is unchanged.
- R8: A write landing on the wrap cycle is not picked up at that wrap. It is loaded at the following wrap, so `settled_o` stays low for exactly one full old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source oscillator clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Ratio write strobe |
| wr_ratio_i | input | CODE_W | Ratio code to program |
| pll_ref_busy_i | input | 1 | An enabled PLL uses the divided clock as its reference |
| tick_o | output | 1 | Divided clock enable pulse |
| settled_o | output | 1 | Output runs at the programmed ratio |

## Verification
Two events can fall in the same cycle: a ratio write and the counter wrap that loads the pending ratio. The bench provokes this by waiting until it samples `tick_o` high, then driving the write across that same edge. It judges the result by counting the low samples of `settled_o`, which must equal one full old period. A write placed in the cycle just after a wrap gives the contrasting case: there the flag must stay low for one cycle less than the period.

// File: rtl/osc_div_pkg.sv
package osc_div_pkg;

   // Last count value of one output period for ratio code 'code'.
   function automatic int unsigned div_last(input int unsigned code);
      return (32'd1 << code) - 32'd1;
   endfunction

endpackage

// File: rtl/osc_ratio_shadow.sv
module osc_ratio_shadow #(
   parameter int CODE_W     = 2,
   parameter int RESET_CODE = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [CODE_W-1:0] wr_ratio_i,
   input  logic              busy_i,
   output logic [CODE_W-1:0] prog_o
);

   logic [CODE_W-1:0] prog_q;
   logic              accept;

   // A write is taken only while no enabled PLL references the output.
   assign accept = wr_en_i & ~busy_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prog_q <= CODE_W'(RESET_CODE);
      end else if (accept) begin
         prog_q <= wr_ratio_i;
      end
   end

   assign prog_o = prog_q;

   // R7: a write made while the reference is busy leaves the programmed code alone.
   a_r7_busy_ignored : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && busy_i) |=> $stable(prog_q));

endmodule

// File: rtl/osc_div_counter.sv
module osc_div_counter #(
   parameter int CODE_W     = 2,
   parameter int RESET_CODE = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] prog_i,
   output logic [CODE_W-1:0] active_o,
   output logic              tick_o
);
   import osc_div_pkg::*;

   localparam int NUM_CODES = 1 << CODE_W;
   localparam int CNT_W     = (NUM_CODES > 2) ? NUM_CODES - 1 : 1;

   logic [CNT_W-1:0]     cnt_q;
   logic [CODE_W-1:0]    active_q;
   logic [NUM_CODES-1:0] hit;
   logic                 wrap;

   // One terminal-count comparator per ratio code; the active code picks one.
   for (genvar k = 0; k < NUM_CODES; k++) begin : g_term
      assign hit[k] = (cnt_q == CNT_W'(div_last(k)));
   end

   assign wrap = hit[active_q];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         active_q <= CODE_W'(RESET_CODE);
      end else if (wrap) begin
         cnt_q    <= '0;
         active_q <= prog_i;
      end else begin
         cnt_q    <= cnt_q + CNT_W'(1);
      end
   end

   assign active_o = active_q;
   assign tick_o   = wrap;

   // R5: the active ratio only changes at a period boundary (counter restarts at zero).
   a_r5_load_at_wrap : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_q != $past(active_q)) |-> (cnt_q == '0));

   // R1: at a ratio other than 1, a tick is followed by a quiet cycle.
   a_r1_tick_single : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && (active_q != '0) && (prog_i == active_q)) |=> !tick_o);

endmodule

// File: rtl/osc_div_status.sv
module osc_div_status #(
   parameter int CODE_W = 2
) (
   input  logic [CODE_W-1:0] prog_i,
   input  logic [CODE_W-1:0] active_i,
   output logic              settled_o
);

   // The output is settled when the running ratio equals the programmed one.
   always_comb begin
      settled_o = (prog_i == active_i);
   end

endmodule

// File: rtl/osc_ratio_div.sv
module osc_ratio_div #(
   parameter int CODE_W     = 2,
   parameter int RESET_CODE = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [CODE_W-1:0] wr_ratio_i,
   input  logic              pll_ref_busy_i,
   output logic              tick_o,
   output logic              settled_o
);

   localparam int NUM_CODES = 1 << CODE_W;

   if (CODE_W < 1 || CODE_W > 3) begin : g_bad_code_w
      $error("osc_ratio_div: CODE_W must lie in 1..3");
   end
   if (RESET_CODE < 0 || RESET_CODE >= NUM_CODES) begin : g_bad_reset_code
      $error("osc_ratio_div: RESET_CODE out of range");
   end

   logic [CODE_W-1:0] prog;
   logic [CODE_W-1:0] active;

   osc_ratio_shadow #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_shadow (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_ratio_i (wr_ratio_i),
      .busy_i     (pll_ref_busy_i),
      .prog_o     (prog)
   );

   osc_div_counter #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_counter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .prog_i   (prog),
      .active_o (active),
      .tick_o   (tick_o)
   );

   osc_div_status #(.CODE_W(CODE_W)) u_status (
      .prog_i    (prog),
      .active_i  (active),
      .settled_o (settled_o)
   );

   // R3: an accepted write of a code that differs from both held codes clears the flag.
   a_r3_flag_drop : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !pll_ref_busy_i && (wr_ratio_i != prog) && (wr_ratio_i != active))
      |=> !settled_o);

   // R4: rewriting the settled ratio keeps the flag high.
   a_r4_same_ratio : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (settled_o && wr_en_i && (wr_ratio_i == prog)) |=> settled_o);

endmodule

// File: tb/test_osc_ratio_div.sv
module test_osc_ratio_div;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_ratio = 2'd0;
   logic       busy = 1'b0;
   logic       tick;
   logic       settled;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int cur    = 0;

   always #2 clk = ~clk;   // 250 MHz

   osc_ratio_div i_osc_ratio_div (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .wr_en_i        (wr_en),
      .wr_ratio_i     (wr_ratio),
      .pll_ref_busy_i (busy),
      .tick_o         (tick),
      .settled_o      (settled)
   );

   // Vector: {busy, code}
   localparam logic [2:0] VEC [8] = '{3'b010, 3'b010, 3'b011, 3'b100,
                                      3'b001, 3'b000, 3'b111, 3'b011};

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         errors = errors + 1;
         $display("FAIL watchdog expired got %0d exp %0d", cycles, 20000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input int got, input int exp);
      checks = checks + 1;
      if (got != exp) begin
         errors = errors + 1;
         $display("FAIL %s got %0d exp %0d", req, got, exp);
      end
   endtask

   // Issue one write cycle, starting and ending on a falling edge.
   task automatic do_write(input logic b, input logic [1:0] code);
      wr_en = 1'b1; wr_ratio = code; busy = b;
      @(negedge clk);
      wr_en = 1'b0; busy = 1'b0;
   endtask

   // Count samples with settled low, starting at the current sample.
   task automatic count_low(output int n);
      n = 0;
      while (!settled && n < 40) begin
         n = n + 1;
         @(negedge clk);
      end
   endtask

   task automatic count_ticks(output int n);
      n = 0;
      for (int i = 0; i < 16; i++) begin
         if (tick) n = n + 1;
         @(negedge clk);
      end
   endtask

   initial begin
      int n;
      int exp_cur;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 settled after reset", int'(settled), 1);
      check("R2 tick after reset", int'(tick), 1);
      count_ticks(n);
      check("R1 code 0 tick always high", n, 16);

      foreach (VEC[v]) begin
         exp_cur = VEC[v][2] ? cur : int'(VEC[v][1:0]);
         do_write(VEC[v][2], VEC[v][1:0]);
         if (VEC[v][2])
            check("R7 busy write keeps flag", int'(settled), 1);
         else if (exp_cur == cur)
            check("R4 same ratio keeps flag", int'(settled), 1);
         else
            check("R3 flag drops after write", int'(settled), 0);
         count_low(n);
         check("R5 settle within old period", int'(n <= (1 << cur)), 1);
         check("R6 flag returns", int'(settled), 1);
         count_ticks(n);
         check("R1 tick count at new ratio", n, 16 >> exp_cur);
         cur = exp_cur;
      end

      // R8: write coinciding with the wrap (current code 3 -> set code 2 first).
      do_write(1'b0, 2'd2);
      count_low(n);
      cur = 2;
      while (!tick) @(negedge clk);
      do_write(1'b0, 2'd1);
      count_low(n);
      check("R8 wrap-cycle write waits full old period", n, 4);
      count_ticks(n);
      check("R6 tick count after wrap-cycle write", n, 8);
      cur = 1;

      // Contrast: write in the cycle just after a wrap.
      while (!tick) @(negedge clk);
      @(negedge clk);
      do_write(1'b0, 2'd0);
      count_low(n);
      check("R5 mid-period write waits rest of period", n, 1);
      count_ticks(n);
      check("R1 back to divide by one", n, 16);

      // R7: busy held while a different code is offered.
      do_write(1'b1, 2'd3);
      check("R7 busy write flag", int'(settled), 1);
      count_ticks(n);
      check("R7 busy write spacing unchanged", n, 16);

      // Reset in the middle of a slow ratio.
      do_write(1'b0, 2'd3);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 settled after mid-run reset", int'(settled), 1);
      check("R2 tick after mid-run reset", int'(tick), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule